// File: doc/BRIEF.md
# Instruction Stream Prefetch Buffer

This block works next to an instruction cache and holds a short run of instruction lines fetched ahead of need. Every fetch request is looked up in the buffer in the same cycle as in the cache. When the cache hits, the buffer stays out of the way. When the cache misses but the buffer holds the line, the buffer returns the line to the fetch pipeline in that same cycle. It also drives a fill of that line into the cache.

When neither the cache nor the buffer holds the line, the buffer drops whatever it held. It then claims four entries for the missing line and the three lines after it, and requests them from the next memory level one after another. A fetch that names a line already requested but not yet returned simply waits for the data. A flush (for example on a branch redirect) cancels every entry. Returns for requests that were still outstanding at a flush or restart are counted off and thrown away.

Memory returns responses in the order it accepted the requests, and never earlier than the cycle after acceptance. Addresses on every port are line addresses, so consecutive lines differ by one.

Top module: `sbuf_top`

## Requirements
- R1: After reset, no entry is valid, and `memReqValid`, `pipeValid` and `fillValid` are all low.
- R2: A fetch with `cacheHit` low whose line matches no buffer entry starts a burst. From the next cycle, exactly four requests are presented in order, for lines L, L+1, L+2 and L+3, where L is the fetch line.
- R3: A fetch with `cacheHit` low that matches an entry holding data raises `pipeValid` and `fillValid` in the same cycle. Both carry that entry's line data, and `fillLine` equals the fetch line.
- R4: A fetch with `cacheHit` high produces no pipeline or fill output and issues no request. It leaves the buffer contents unchanged.
- R5: A fetch that matches an entry still waiting for data issues no new request. It receives the line in the cycle after the memory response for it arrives.
- R6: Starting a new burst invalidates every earlier entry, so lines of the previous burst no longer hit.
- R7: A flush cancels all entries. In the next cycle `memReqValid` and `pipeValid` are low, and later fetches of the cancelled lines do not hit.
- R8: Memory responses fill the entries in request order, so the k-th response of a burst is delivered for line L+k.
- R9: Responses to requests cancelled by a flush or a restart are discarded. No request of a new burst is presented until all of them have arrived.
- R10: While `memReqValid` is high and `memReqReady` is low, the request stays presented with the same `memReqLine` until it is accepted, unless it is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch request present |
| fetchLine | input | ADDR_W | Line address of the fetch |
| cacheHit | input | 1 | Instruction cache hit for the fetch in this cycle |
| flush | input | 1 | Redirect: cancel all entries and outstanding requests |
| memReqValid | output | 1 | Line request to memory presented |
| memReqReady | input | 1 | Memory accepts the request |
| memReqLine | output | ADDR_W | Requested line address |
| memRspValid | input | 1 | Memory returns one line |
| memRspData | input | LINE_W | Returned line data |
| fillValid | output | 1 | Cache fill strobe |
| fillLine | output | ADDR_W | Line address to fill |
| fillData | output | LINE_W | Line data to fill |
| pipeValid | output | 1 | Line delivered to the fetch pipeline |
| pipeData | output | LINE_W | Delivered line data |

## Verification
The risky overlap is a burst restart, caused by a fetch that misses in both cache and buffer, falling in the same cycle as a memory return from the burst being abandoned. The bench watches its own memory model. When a response is on the bus, it fires a missing fetch to a different line in that exact cycle. It then requires that all four new lines come back carrying their own data, with no stale line slipping into an entry. A second case issues a flush while four returns are held back. It checks that no new request appears until those returns drain, and that only fresh data is delivered afterwards.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int SB_ENTRIES = 4;
  localparam int SB_IDX_W   = $clog2(SB_ENTRIES + 1);

  typedef logic [SB_IDX_W-1:0] sbIdx_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   alloc;    // claim all entries for a new burst
    logic   clear;    // cancel all entries
    logic   fill;     // write a memory return into entry fillIdx
    sbIdx_t fillIdx;
    sbIdx_t reqIdx;   // entry whose tag is presented to memory
  } sbStrobe_t;
endpackage

// File: rtl/sbuf_datapath.sv
module sbuf_datapath
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strb,
  input  logic [ADDR_W-1:0] fetchLine,
  input  logic [LINE_W-1:0] rspData,
  output logic              hitRdy,
  output logic              hitPend,
  output logic [LINE_W-1:0] hitData,
  output logic [ADDR_W-1:0] reqLine
);
  localparam int N = SB_ENTRIES;

  logic [N-1:0]        entVld;
  logic [N-1:0]        entRdy;
  logic [ADDR_W-1:0]   entTag  [N];
  logic [LINE_W-1:0]   entData [N];
  logic [N-1:0]        hitVec;

  for (genvar g = 0; g < N; g++) begin : gCmp
    assign hitVec[g] = entVld[g] && (entTag[g] == fetchLine);
  end

  assign hitRdy  = |(hitVec & entRdy);
  assign hitPend = |(hitVec & ~entRdy);

  always_comb begin
    hitData = '0;
    for (int i = 0; i < N; i++)
      if (hitVec[i]) hitData = hitData | entData[i];
  end

  always_comb begin
    reqLine = '0;
    for (int i = 0; i < N; i++)
      if (strb.reqIdx == SB_IDX_W'(i)) reqLine = entTag[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entVld <= '0;
      entRdy <= '0;
      for (int i = 0; i < N; i++) entTag[i] <= '0;
    end else if (strb.clear) begin
      entVld <= '0;
      entRdy <= '0;
    end else if (strb.alloc) begin
      entVld <= '1;
      entRdy <= '0;
      for (int i = 0; i < N; i++) entTag[i] <= fetchLine + ADDR_W'(i);
    end else if (strb.fill) begin
      for (int i = 0; i < N; i++)
        if (strb.fillIdx == SB_IDX_W'(i)) entRdy[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill && !strb.clear && !strb.alloc)
      for (int i = 0; i < N; i++)
        if (strb.fillIdx == SB_IDX_W'(i)) entData[i] <= rspData;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec)); // R3
  AST_FILL_PENDING: assert property (@(posedge clk) disable iff (!rstN) strb.fill && !strb.clear && !strb.alloc |-> entVld != '0); // R8
endmodule

// File: rtl/sbuf_control.sv
module sbuf_control
  import sbuf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      fetchValid,
  input  logic      cacheHit,
  input  logic      flush,
  input  logic      hitRdy,
  input  logic      hitPend,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      memReqValid,
  output logic      bufHit,
  output sbStrobe_t strb
);
  localparam int     N    = SB_ENTRIES;
  localparam int     W    = SB_IDX_W;
  localparam int     CW   = W + 1;
  localparam sbIdx_t IDLE = sbIdx_t'(N);
  localparam sbIdx_t ONE  = sbIdx_t'(1);

  sbIdx_t reqIdx, rspIdx;
  sbIdx_t dropCnt;   // cancelled returns still to arrive

  logic lookup, missAll, cancel, reqFire, dropNow, keepRsp;
  logic [CW-1:0] inFlight;

  assign lookup      = fetchValid && !cacheHit && !flush;
  assign bufHit      = lookup && hitRdy;
  assign missAll     = lookup && !hitRdy && !hitPend;
  assign cancel      = flush || missAll;
  assign memReqValid = (reqIdx < IDLE) && (dropCnt == '0);
  assign reqFire     = memReqValid && memReqReady;
  assign dropNow     = memRspValid && (dropCnt != '0);
  assign keepRsp     = memRspValid && (dropCnt == '0) && (rspIdx < reqIdx);
  assign inFlight    = CW'(dropCnt) + CW'(reqIdx - rspIdx) + CW'(reqFire) - CW'(memRspValid);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqIdx  <= IDLE;
      rspIdx  <= IDLE;
      dropCnt <= '0;
    end else if (cancel) begin
      dropCnt <= sbIdx_t'(inFlight);
      reqIdx  <= missAll ? '0 : IDLE;
      rspIdx  <= missAll ? '0 : IDLE;
    end else begin
      if (reqFire) reqIdx  <= reqIdx + ONE;
      if (keepRsp) rspIdx  <= rspIdx + ONE;
      if (dropNow) dropCnt <= dropCnt - ONE;
    end
  end

  always_comb begin
    strb.alloc   = missAll;
    strb.clear   = flush;
    strb.fill    = keepRsp && !cancel;
    strb.fillIdx = rspIdx;
    strb.reqIdx  = reqIdx;
  end

  AST_RSP_BEHIND_REQ: assert property (@(posedge clk) disable iff (!rstN) rspIdx <= reqIdx); // R8
  AST_DRAIN_FIRST: assert property (@(posedge clk) disable iff (!rstN) dropCnt != '0 |-> rspIdx == reqIdx); // R9
  AST_MISS_ARMS: assert property (@(posedge clk) disable iff (!rstN) missAll |=> reqIdx == '0 && rspIdx == '0); // R2
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchLine,
  input  logic              cacheHit,
  input  logic              flush,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqLine,
  input  logic              memRspValid,
  input  logic [LINE_W-1:0] memRspData,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillLine,
  output logic [LINE_W-1:0] fillData,
  output logic              pipeValid,
  output logic [LINE_W-1:0] pipeData
);
  sbStrobe_t         strb;
  logic              hitRdy, hitPend, bufHit;
  logic [LINE_W-1:0] hitData;

  sbuf_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .cacheHit   (cacheHit),
    .flush      (flush),
    .hitRdy     (hitRdy),
    .hitPend    (hitPend),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memReqValid(memReqValid),
    .bufHit     (bufHit),
    .strb       (strb)
  );

  sbuf_datapath #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .fetchLine(fetchLine),
    .rspData  (memRspData),
    .hitRdy   (hitRdy),
    .hitPend  (hitPend),
    .hitData  (hitData),
    .reqLine  (memReqLine)
  );

  assign pipeValid = bufHit;
  assign pipeData  = hitData;
  assign fillValid = bufHit;
  assign fillLine  = fetchLine;
  assign fillData  = hitData;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN) memReqValid && !memReqReady && !flush && !strb.alloc |=> memReqValid && $stable(memReqLine)); // R10
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN) flush |=> !memReqValid && !pipeValid); // R7
  AST_CACHE_QUIET: assert property (@(posedge clk) disable iff (!rstN) fetchValid && cacheHit && !memReqValid |=> !memReqValid); // R4
endmodule

// File: tb/tb_sbuf_top.sv
`timescale 1ns/1ps
module tb_sbuf_top;
  localparam int AW = 28;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rstN;
  logic          fetchValid, cacheHit, flush;
  logic [AW-1:0] fetchLine;
  logic          memReqValid, memReqReady;
  logic [AW-1:0] memReqLine;
  logic          memRspValid;
  logic [LW-1:0] memRspData;
  logic          fillValid, pipeValid;
  logic [AW-1:0] fillLine;
  logic [LW-1:0] fillData, pipeData;

  int checks = 0;
  int errors = 0;
  bit holdReady = 1'b0;
  bit rspHold   = 1'b0;
  logic [AW-1:0] memQ[$];
  logic [AW-1:0] reqLog[$];

  always #2 clk = ~clk;

  sbuf_top #(.ADDR_W(AW), .LINE_W(LW)) dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchLine(fetchLine),
    .cacheHit(cacheHit), .flush(flush), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqLine(memReqLine), .memRspValid(memRspValid),
    .memRspData(memRspData), .fillValid(fillValid), .fillLine(fillLine),
    .fillData(fillData), .pipeValid(pipeValid), .pipeData(pipeData)
  );

  function automatic logic [LW-1:0] dataOf(logic [AW-1:0] l);
    logic [31:0] w;
    w = {4'h0, l};
    return {w, ~w, w + 32'h1357, w ^ 32'h5a5a5a5a};
  endfunction

  // Memory model: in-order, at least one cycle of latency
  always @(negedge clk) begin
    memReqReady = !holdReady;
    if (rstN && !rspHold && memQ.size() > 0) begin
      memRspValid = 1'b1;
      memRspData  = dataOf(memQ.pop_front());
    end else begin
      memRspValid = 1'b0;
      memRspData  = '0;
    end
    if (rstN && memReqValid && memReqReady) begin
      memQ.push_back(memReqLine);
      reqLog.push_back(memReqLine);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    fetchValid = 1'b0; cacheHit = 1'b0; flush = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin step(); idle(); end
  endtask

  // Hold a fetch until the line is delivered; check data and fill
  task automatic fetchUntil(input logic [AW-1:0] l, input string req);
    bit got;
    got = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      step();
      fetchValid = 1'b1; fetchLine = l; cacheHit = 1'b0; flush = 1'b0;
      #0.5;
      if (pipeValid) begin
        got = 1'b1;
        chk(pipeData == dataOf(l), req, pipeData, dataOf(l));
        chk(fillValid && fillLine == l && fillData == dataOf(l), req, {fillValid, fillLine}, {1'b1, l});
      end
    end
    chk(got, req, LW'(got), LW'(1));
    step(); idle();
  endtask

  // One-cycle fetch expected to hit immediately
  task automatic fetchHit(input logic [AW-1:0] l, input string req);
    step();
    fetchValid = 1'b1; fetchLine = l; cacheHit = 1'b0; flush = 1'b0;
    #0.5;
    chk(pipeValid && pipeData == dataOf(l), req, {pipeValid, pipeData[LW-2:0]}, {1'b1, dataOf(l)[LW-2:0]});
    chk(fillValid && fillLine == l, req, LW'(fillLine), LW'(l));
  endtask

  // One-cycle fetch expected to miss in the buffer
  task automatic fetchMiss(input logic [AW-1:0] l, input string req);
    step();
    fetchValid = 1'b1; fetchLine = l; cacheHit = 1'b0; flush = 1'b0;
    #0.5;
    chk(!pipeValid && !fillValid, req, LW'(pipeValid), LW'(0));
  endtask

  task automatic testReset();
    chk(!memReqValid && !pipeValid && !fillValid, "R1 reset outputs", {memReqValid, pipeValid, fillValid}, '0);
  endtask

  task automatic testBurst(input logic [AW-1:0] a);
    int base;
    base = reqLog.size();
    holdReady = 1'b1;
    step();
    fetchValid = 1'b1; fetchLine = a; cacheHit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      #0.5;
      chk(memReqValid && memReqLine == a, "R10 request held", {memReqValid, memReqLine}, {1'b1, a});
    end
    holdReady = 1'b0;
    fetchUntil(a, "R5 pending fetch waits");
    settle(10);
    chk(reqLog.size() == base + 4, "R5 R2 exactly four requests", LW'(reqLog.size() - base), LW'(4));
    for (int k = 0; k < 4; k++)
      chk(reqLog[base + k] == a + AW'(k), "R2 request order", LW'(reqLog[base + k]), LW'(a + AW'(k)));
    for (int k = 1; k < 4; k++) fetchHit(a + AW'(k), "R8 R3 in-order fill hit");
    step(); idle();
  endtask

  task automatic testCacheHit(input logic [AW-1:0] a);
    int base;
    base = reqLog.size();
    step();
    fetchValid = 1'b1; fetchLine = a + 2; cacheHit = 1'b1;
    #0.5;
    chk(!pipeValid && !fillValid, "R4 cache hit quiet", {pipeValid, fillValid}, '0);
    step(); idle();
    settle(3);
    chk(reqLog.size() == base, "R4 no request on cache hit", LW'(reqLog.size()), LW'(base));
    fetchHit(a + 2, "R4 buffer unchanged");
    step(); idle();
  endtask

  task automatic testRestart(input logic [AW-1:0] a, input logic [AW-1:0] b);
    int base;
    fetchUntil(b, "R3 new burst first line");
    settle(8);
    base = reqLog.size();
    fetchMiss(a, "R6 old lines invalidated");
    step(); idle();
    settle(10);
    chk(reqLog.size() == base + 4 && reqLog[base] == a, "R6 old line refetched", LW'(reqLog[base]), LW'(a));
    fetchHit(a + 3, "R8 refetched last line");
    step(); idle();
  endtask

  task automatic testFlush(input logic [AW-1:0] c, input logic [AW-1:0] d);
    rspHold = 1'b1;
    fetchMiss(c, "R2 flush-case burst start");
    step(); idle();
    settle(6);
    step();
    flush = 1'b1;
    step(); idle();
    #0.5;
    chk(!memReqValid && !pipeValid, "R7 quiet after flush", {memReqValid, pipeValid}, '0);
    fetchValid = 1'b1; fetchLine = d;
    for (int k = 0; k < 4; k++) begin
      step();
      #0.5;
      chk(!memReqValid, "R9 no request while draining", LW'(memReqValid), LW'(0));
    end
    rspHold = 1'b0;
    fetchUntil(d, "R7 R9 fresh data after flush");
    for (int k = 1; k < 4; k++) fetchHit(d + AW'(k), "R8 post-flush order");
    step(); idle();
    fetchMiss(c + 1, "R7 cancelled line misses");
    step(); idle();
    settle(12);
  endtask

  task automatic testOverlap(input logic [AW-1:0] e, input logic [AW-1:0] f);
    bit seen;
    seen = 1'b0;
    fetchMiss(e, "R2 overlap burst start");
    step(); idle();
    for (int i = 0; i < 20 && !seen; i++) begin
      if (memRspValid) seen = 1'b1;
      else step();
    end
    chk(seen, "R9 response observed", LW'(seen), LW'(1));
    fetchValid = 1'b1; fetchLine = f; cacheHit = 1'b0;
    #0.5;
    chk(!pipeValid, "R6 restart cycle miss", LW'(pipeValid), LW'(0));
    fetchUntil(f, "R9 restart with return in flight");
    for (int k = 1; k < 4; k++) fetchHit(f + AW'(k), "R8 restart order");
    step(); idle();
    fetchMiss(e + 1, "R6 abandoned burst misses");
    step(); idle();
    settle(12);
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    fetchLine = '0;
    memReqReady = 1'b1; memRspValid = 1'b0; memRspData = '0;
    settle(5);
    rstN = 1'b1;
    step();
    testReset();
    testBurst(28'h100);
    testCacheHit(28'h100);
    testRestart(28'h100, 28'h200);
    testFlush(28'h300, 28'h400);
    testOverlap(28'h500, 28'h600);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule